// File: doc/BRIEF.md
# Prescaled Timer/Counter with Buffered High Byte

This block is a small timer/counter peripheral held in the system clock domain. It counts either the chip's instruction-cycle ticks, which arrive as single-cycle `tick` pulses, or edges on an external input pin. The external pin is brought in through a two-flop synchronizer. The counted edge can be rising or falling. Counting can pass through an optional power-of-two prescaler. The counter works as either an 8-bit or a 16-bit register, and it raises a sticky overflow flag each time it wraps to zero.

Software reaches the block through a three-address register port: the control register, the low count byte, and a high-byte buffer. In 16-bit mode the high byte is only accessed through the buffer, which makes 16-bit reads and writes atomic. A read of the low byte copies the live high byte into the buffer. A write of the low byte loads the buffered high byte into the counter together with the new low byte.

Every write of the low count byte does two things. It empties the prescaler, and it blocks counting for the next two instruction ticks.

Top module: `prog_timer`

## Requirements
- R1: After reset, the control register reads 0xFF, the low count byte reads 0x00 and the overflow flag is 0.
- R2: The register addresses are: 0 for the control register, 1 for the low count byte, 2 for the high-byte buffer. Read data is combinational from `addr`. The control bits are: bit 7 run enable, bit 6 8-bit mode, bit 5 external source, bit 4 falling-edge select, bit 3 prescaler bypass, bits 2:0 prescale select.
- R3: With bit 5 = 0, each `tick` pulse is one counting event. With bit 5 = 1, each synchronized rising edge of `ext_in` (bit 4 = 0) or falling edge (bit 4 = 1) is one counting event.
- R4: With bit 3 = 0, the counter advances once every 2^(n+1) counting events, where n is the prescale select (1:2 up to 1:256). With bit 3 = 1, it advances on every event. A write of the low count byte resets the prescaler.
- R5: After a write of the low count byte, the next two `tick` pulses are consumed. Counting events that occur before those two ticks have passed are discarded.
- R6: In 16-bit mode, a read of address 1 returns the live low byte and copies the live high byte into the buffer. A following read of address 2 returns that copy.
- R7: A write of address 2 changes only the buffer and leaves the counter alone. In 16-bit mode, a write of address 1 sets the counter to {buffer, data}.
- R8: In 8-bit mode only the low byte counts, and a write of address 1 leaves the counter's high byte unchanged.
- R9: The overflow flag is set when the counter wraps from 0xFF to 0x00 in 8-bit mode, or from 0xFFFF to 0x0000 in 16-bit mode.
- R10: The overflow flag stays set until `ovf_clr` is asserted. If a wrap and a clear happen in the same cycle, the set wins.
- R11: With bit 7 = 0, the counter and prescaler hold their values, while register writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Instruction-cycle tick, one clock wide |
| ext_in | input | 1 | Asynchronous external count input |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench aims at off-by-one cases around the write inhibit. Exactly two ticks after a write should produce no count and three should produce one. A design that inhibits the wrong number of ticks misses that count or gains an extra one.

It also drives the prescaler at its full 1:256 ratio, one event short of a count and exactly on one. A wrong mask width or a missing prescaler clear shows up as an early or late count.

For atomic access, the bench writes the buffer between reads and expects the live high byte to come back. A design that lets a buffer write reach the counter, or that fails to latch on the low read, returns the wrong byte. 8-bit wraps are checked for a high byte that stays untouched, and the random trials mix source, polarity and mode against a computed event count.

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 8,
  parameter logic [7:0] CTRL_RST = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ext_in,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ovf_clr,
  output logic       ovf_flag
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LO   = 2'd1;
  localparam logic [1:0] A_HI   = 2'd2;
  localparam logic [1:0] INH_TICKS = 2'd2;

  logic [7:0]         ctrl;
  logic [15:0]        cnt;
  logic [7:0]         hbuf;
  logic [PRE_W-1:0]   pre;
  logic [1:0]         inh;
  logic [SYNC_STAGES:0] sy;

  wire run   = ctrl[7];
  wire m8    = ctrl[6];
  wire src_x = ctrl[5];
  wire fe    = ctrl[4];
  wire byp   = ctrl[3];
  wire [2:0] ps = ctrl[2:0];

  wire cur = sy[SYNC_STAGES-1];
  wire prv = sy[SYNC_STAGES];
  wire ev  = src_x ? (fe ? (~cur & prv) : (cur & ~prv)) : tick;

  wire ct_wr  = wr_en && addr == A_CTRL;
  wire cnt_wr = wr_en && addr == A_LO;
  wire hb_wr  = wr_en && addr == A_HI;
  wire lo_rd  = rd_en && addr == A_LO;

  logic [PRE_W:0]   one_sh;
  logic [PRE_W-1:0] mask;
  assign one_sh = {{PRE_W{1'b0}}, 1'b1} << ({1'b0, ps} + 4'd1);
  assign mask   = one_sh[PRE_W-1:0] - 1'b1;

  wire gated = ev && run && inh == 2'd0 && !cnt_wr;
  wire inc   = gated && (byp || (pre & mask) == mask);
  wire wrap  = inc && (m8 ? &cnt[7:0] : &cnt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '0;
    else        sy <= {sy[SYNC_STAGES-1:0], ext_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   inh <= 2'd0;
    else if (cnt_wr)              inh <= INH_TICKS;
    else if (tick && inh != 2'd0) inh <= inh - 2'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              pre <= '0;
    else if (cnt_wr)         pre <= '0;
    else if (gated && !byp)  pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (cnt_wr)  cnt <= m8 ? {cnt[15:8], wdata} : {hbuf, wdata};
    else if (inc)     cnt <= m8 ? {cnt[15:8], cnt[7:0] + 8'd1} : cnt + 16'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             hbuf <= '0;
    else if (hb_wr)         hbuf <= wdata;
    else if (lo_rd && !m8)  hbuf <= cnt[15:8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctrl <= CTRL_RST;
    else if (ct_wr)  ctrl <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (wrap)     ovf_flag <= 1'b1;
    else if (ovf_clr)  ovf_flag <= 1'b0;

  always_comb
    case (addr)
      A_CTRL:  rdata = ctrl;
      A_LO:    rdata = cnt[7:0];
      A_HI:    rdata = hbuf;
      default: rdata = 8'h00;
    endcase

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);

  // R11
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_wr |=> $stable(cnt) && $stable(pre));

  // R5
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inh != 2'd0 && !cnt_wr |=> $stable(cnt));

  // R8
  high_hold_8bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m8 && !ct_wr |=> $stable(cnt[15:8]));

  // R9
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(cnt[7:0]) == 8'hFF && cnt[7:0] == 8'h00);
endmodule

// File: tb/tb_prog_timer.sv
`timescale 1ns/1ps
module tb_prog_timer;
  logic clk = 0, rst_n = 0, tick = 0, ext_in = 0, wr_en = 0, rd_en = 0, ovf_clr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic ovf_flag;
  int checks = 0, errors = 0;
  bit done = 0;

  prog_timer dut (.clk, .rst_n, .tick, .ext_in, .wr_en, .rd_en, .addr, .wdata,
                  .rdata, .ovf_clr, .ovf_flag);

  always #5 clk = ~clk;

  task automatic step(); @(posedge clk); #1; endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; step(); wr_en = 0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1; #1; d = rdata; step(); rd_en = 0;
  endtask
  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd1, lo); rd(2'd2, hi); v = {hi, lo};
  endtask
  task automatic ticks(input int n);
    repeat (n) begin tick = 1; step(); tick = 0; step(); end
  endtask
  task automatic pulses(input int n, input bit fe);
    repeat (n) begin ext_in = ~fe; repeat (3) step(); ext_in = fe; repeat (3) step(); end
  endtask
  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_incs(bit ext, bit byp, int ps, int n);
    int eff = ext ? n : (n > 2 ? n - 2 : 0);
    return byp ? eff : eff >> (ps + 1);
  endfunction

  function automatic logic [7:0] mk_ctrl(bit run, bit m8, bit ext, bit fe, bit byp, int ps);
    return {run, m8, ext, fe, byp, 3'(ps)};
  endfunction

  task automatic trial(input string req, input bit m8, input bit ext, input bit fe,
                       input bit byp, input int ps, input logic [7:0] h,
                       input logic [7:0] l, input int n);
    logic [7:0] v8; logic [15:0] v16; int inc, sum;
    ext_in = fe; repeat (4) step();
    wr(2'd0, mk_ctrl(1, m8, ext, fe, byp, ps));
    wr(2'd2, h); wr(2'd1, l);
    ovf_clr = 1; step(); ovf_clr = 0;
    if (ext) begin ticks(2); pulses(n, fe); end else ticks(n);
    repeat (4) step();
    inc = exp_incs(ext, byp, ps, n);
    if (m8) begin
      sum = int'(l) + inc;
      rd(2'd1, v8);
      check(req, v8, sum & 8'hFF);
      check({req, " R9 ovf8"}, ovf_flag, sum > 255);
    end else begin
      sum = int'({h, l}) + inc;
      rd16(v16);
      check(req, v16, sum & 16'hFFFF);
      check({req, " R9 ovf16"}, ovf_flag, sum > 65535);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic [15:0] v;
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) step(); rst_n = 1; step();

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 8'hFF);
    rd(2'd1, d); check("R1 low", d, 0);
    check("R1 ovf", ovf_flag, 0);

    // R5 inhibit edges (internal, bypass, 8-bit)
    trial("R5 two ticks", 1, 0, 0, 1, 0, 8'h00, 8'h10, 2);
    trial("R5 three ticks", 1, 0, 0, 1, 0, 8'h00, 8'h10, 3);

    // R4 full ratio
    trial("R4 1:256 short", 1, 0, 0, 0, 7, 8'h00, 8'h40, 257);
    trial("R4 1:256 exact", 1, 0, 0, 0, 7, 8'h00, 8'h40, 258);

    // R4 prescaler cleared by count write
    wr(2'd0, mk_ctrl(1, 1, 0, 0, 0, 1));
    wr(2'd1, 8'h00); ticks(5);
    wr(2'd1, 8'h00); ticks(5);
    rd(2'd1, d); check("R4 prescaler clear", d, 8'h00);

    // R3 external polarity
    trial("R3 rising", 1, 1, 0, 1, 0, 8'h00, 8'h05, 7);
    trial("R3 falling", 1, 1, 1, 1, 0, 8'h00, 8'h05, 9);

    // R7 / R6 buffered access
    wr(2'd0, mk_ctrl(0, 0, 0, 0, 1, 0));
    wr(2'd2, 8'h12); wr(2'd1, 8'h34);
    rd16(v); check("R7 atomic load", v, 16'h1234);
    wr(2'd2, 8'h99);
    rd(2'd2, d); check("R2 buffer readback", d, 8'h99);
    rd16(v); check("R6 latch live high", v, 16'h1234);

    // R11 disabled holds, writes still land
    wr(2'd0, 8'h48); wr(2'd1, 8'h20); ticks(10);
    rd(2'd0, d); check("R11 ctrl written while off", d, 8'h48);
    rd(2'd1, d); check("R11 held", d, 8'h20);
    wr(2'd0, 8'hC8); ticks(5);
    rd(2'd1, d); check("R11 resumes", d, 8'h25);

    // R8 high byte untouched in 8-bit mode
    wr(2'd0, mk_ctrl(1, 0, 0, 0, 1, 0));
    wr(2'd2, 8'h5A); wr(2'd1, 8'h00);
    wr(2'd0, mk_ctrl(1, 1, 0, 0, 1, 0));
    wr(2'd1, 8'hFF); ticks(3);
    check("R8 wrap flag", ovf_flag, 1);
    wr(2'd0, mk_ctrl(0, 0, 0, 0, 1, 0));
    rd16(v); check("R8 high kept", v, 16'h5A00);

    // R10 sticky and clear
    repeat (5) step();
    check("R10 sticky", ovf_flag, 1);
    ovf_clr = 1; step(); ovf_clr = 0;
    check("R10 cleared", ovf_flag, 0);

    // R9 16-bit wrap
    trial("R9 ffff wrap", 0, 0, 0, 1, 0, 8'hFF, 8'hFF, 3);

    // Random trials
    for (int i = 0; i < 24; i++) begin
      bit m8 = 1'($urandom);
      bit ex = 1'($urandom);
      bit fe = 1'($urandom);
      bit by = 1'($urandom);
      int ps = $urandom_range(0, 3);
      logic [7:0] h = 1'($urandom) ? 8'hFF : 8'($urandom);
      logic [7:0] l = 8'($urandom);
      int n = $urandom_range(0, 220);
      trial(ex ? "R3 random ext" : "R2 random int", m8, ex, fe, by, ps, h, l, n);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule